// File: doc/BRIEF.md
# Fixed-Period Simulation Step Sequencer

This controller paces a hardware simulation engine that advances in fixed time steps. A divider on the fast clock marks each step boundary. At every boundary the controller pulses a step tick, which makes the component models latch the previous step's solution and their external switch inputs. In the same cycle it starts the component-update logic. One cycle later it starts the system solver. It then waits for the solver to report completion and idles until the next boundary.

The engine runs only while a run-enable input is high. With run-enable low, the controller sits idle and its divider is cleared. Raising run-enable therefore starts a new step aligned to the first enabled clock edge.

The step is a hard real-time period. If the solver has not reported completion by the next boundary, the controller sets a sticky overrun flag and starts the new step anyway. The step length in fast-clock cycles is a parameter, and any value below 3 is rejected at elaboration. With the default of 10, a 200 MHz fast clock gives a 50 ns step. The solver then has from one to nine cycles to finish.

Top module: `step_seq_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards for as long as run_en stays low, step_tick, comp_start, solver_start and overrun are all low.
- R2: The first clock edge at which run_en is sampled high after idle makes step_tick and comp_start high for exactly the following cycle.
- R3: While run_en stays high, step_tick is high for one cycle in every STEP_CYCLES cycles and low otherwise.
- R4: comp_start is high exactly in the cycles where step_tick is high.
- R5: solver_start is high for exactly one cycle per step, the cycle right after comp_start.
- R6: A solve is pending from the solver_start cycle up to and including the next step_tick cycle. A solver_done sampled high at any edge in that window ends the solve on time and leaves overrun low. This holds even when solver_done arrives at the very edge that begins the next step.
- R7: If a pending solve has not seen solver_done by the next step boundary, overrun goes high in the same cycle as that step_tick. The new step still starts on schedule. overrun then stays high until reset.
- R8: solver_done sampled while no solve is pending (for example in the comp_start cycle) has no effect. It neither ends a later solve nor prevents an overrun.
- R9: Sampling run_en low drops all strobes in the next cycle and returns the controller to idle. Re-enabling restarts the step pattern from the re-enable edge, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Engine run enable; low forces idle and clears the divider |
| solver_done | input | 1 | Completion report from the system solver |
| step_tick | output | 1 | One-cycle pulse at each step boundary; components register fed-back solution |
| comp_start | output | 1 | Start strobe for the component-update entities |
| solver_start | output | 1 | Start strobe for the system solver |
| overrun | output | 1 | Sticky flag: a solve missed its step deadline |

## Verification
A corrupted divider count shows up at once as a step_tick gap other than STEP_CYCLES. The bench catches it at the next boundary, at most one step after the error. A wrong sequencer phase shows up within one or two cycles: solver_start is missing or misplaced relative to comp_start. A wrong phase also misclassifies solver_done, so overrun changes state at the wrong boundary. The bench checks every output in every cycle against a cycle index counted from the enable edge. A fault therefore appears in the first cycle it reaches a port, and latencies on both sides of the deadline pin down when the solve window closes.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

   // Sequencer phases: idle, component update, solver launch,
   // solver running, waiting for the next boundary.
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_COMP  = 3'd1,
      PH_KICK  = 3'd2,
      PH_SOLVE = 3'd3,
      PH_HOLD  = 3'd4
   } seq_phase_t;

   localparam int unsigned MIN_STEP_CYCLES = 3;

endpackage

// File: rtl/step_timer.sv
module step_timer #(
   parameter int unsigned STEP_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic boundary,
   output logic tick_q
);
   localparam int unsigned CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
   localparam bit POW2 = ((STEP_CYCLES & (STEP_CYCLES - 1)) == 0);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;

   generate
      if (POW2) begin : g_wrap
         // Length is a power of two: the counter wraps on its own.
         assign cnt_nxt = cnt_q + 1'b1;
      end else begin : g_cmp
         // Any other length: compare against the last count.
         assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   assign boundary = run_en && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         cnt_q  <= run_en ? cnt_nxt : '0;
         tick_q <= boundary;
      end
   end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import step_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic       boundary,
   input  logic       solver_done,
   output seq_phase_t phase,
   output logic       late
);
   seq_phase_t ph_q;
   seq_phase_t ph_nxt;
   logic       pending;

   assign pending = (ph_q == PH_KICK) || (ph_q == PH_SOLVE);

   always_comb begin
      ph_nxt = ph_q;
      late   = 1'b0;
      if (!run_en) begin
         ph_nxt = PH_IDLE;
      end else if (boundary) begin
         // A boundary always opens a new step; an unfinished solve is late.
         ph_nxt = PH_COMP;
         late   = pending && !solver_done;
      end else begin
         unique case (ph_q)
            PH_COMP:  ph_nxt = PH_KICK;
            PH_KICK:  ph_nxt = solver_done ? PH_HOLD : PH_SOLVE;
            PH_SOLVE: ph_nxt = solver_done ? PH_HOLD : PH_SOLVE;
            default:  ph_nxt = ph_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_nxt;
   end

   assign phase = ph_q;
endmodule

// File: rtl/overrun_latch.sv
module overrun_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic late,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= flag | late;
   end
endmodule

// File: rtl/step_seq_ctrl.sv
module step_seq_ctrl
   import step_seq_pkg::*;
#(
   parameter int unsigned STEP_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic solver_done,
   output logic step_tick,
   output logic comp_start,
   output logic solver_start,
   output logic overrun
);
   generate
      if (STEP_CYCLES < MIN_STEP_CYCLES) begin : g_bad_len
         $error("step_seq_ctrl: STEP_CYCLES must be at least 3");
      end
   endgenerate

   logic       boundary;
   logic       late;
   seq_phase_t phase;

   step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .boundary (boundary),
      .tick_q   (step_tick)
   );

   seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .boundary    (boundary),
      .solver_done (solver_done),
      .phase       (phase),
      .late        (late)
   );

   overrun_latch u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .late  (late),
      .flag  (overrun)
   );

   assign comp_start   = (phase == PH_COMP);
   assign solver_start = (phase == PH_KICK);
endmodule

// File: rtl/step_seq_ctrl_chk.sv
module step_seq_ctrl_chk #(
   parameter int unsigned STEP_CYCLES = 10
) (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic step_tick,
   input logic comp_start,
   input logic solver_start,
   input logic overrun
);
   localparam int unsigned GW = $clog2(STEP_CYCLES + 2) + 1;

   logic [GW-1:0] gap_q;
   logic          gap_ok_q;

   // Cycles since the last tick, valid only across an unbroken run.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= '0;
         gap_ok_q <= 1'b0;
      end else begin
         if (step_tick)                    gap_q <= GW'(1);
         else if (gap_q != {GW{1'b1}})     gap_q <= gap_q + 1'b1;
         if (!run_en)        gap_ok_q <= 1'b0;
         else if (step_tick) gap_ok_q <= 1'b1;
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!step_tick && !comp_start && !solver_start));

   p_tick_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_tick && gap_ok_q) |-> (gap_q == GW'(STEP_CYCLES)));

   p_tick_comp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step_tick |-> comp_start);

   p_solver_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (comp_start && run_en) |=> solver_start);

   p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   p_overrun_at_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> step_tick);
endmodule

bind step_seq_ctrl step_seq_ctrl_chk #(.STEP_CYCLES(STEP_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_en       (run_en),
   .step_tick    (step_tick),
   .comp_start   (comp_start),
   .solver_start (solver_start),
   .overrun      (overrun)
);

// File: tb/step_seq_ctrl_bench.sv
`timescale 1ns/1ps
module step_seq_ctrl_bench;
   localparam int N = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0;
   logic solver_done = 1'b0;
   logic step_tick, comp_start, solver_start, overrun;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // Solver model: done is sampled at the edge lat cycles after the
   // edge that launched solver_start.
   bit model_on = 0;
   int lat = 1;
   int rem = 0;

   always #2 clk = ~clk;

   step_seq_ctrl #(.STEP_CYCLES(N)) u_step_seq_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .solver_done  (solver_done),
      .step_tick    (step_tick),
      .comp_start   (comp_start),
      .solver_start (solver_start),
      .overrun      (overrun)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      if (model_on) begin
         if (solver_start) rem = lat;
         else if (rem > 0) rem = rem - 1;
         solver_done = (rem == 1);
      end
   endtask

   function automatic bit exp_tick(input int k);
      return (k % N) == 0;
   endfunction

   function automatic bit exp_sstart(input int k);
      return (k % N) == 1;
   endfunction

   function automatic bit exp_ovr(input int k, input int l);
      return (l > N - 1) && (k >= N);
   endfunction

   task automatic do_reset();
      rst_n = 0; run_en = 0; solver_done = 0; rem = 0; model_on = 0;
      repeat (2) cyc();
      chk("R1 reset tick", step_tick, 1'b0);
      chk("R1 reset comp", comp_start, 1'b0);
      chk("R1 reset solver", solver_start, 1'b0);
      chk("R1 reset overrun", overrun, 1'b0);
      rst_n = 1;
      repeat (3) begin
         cyc();
         chk("R1 idle tick", step_tick, 1'b0);
         chk("R1 idle comp", comp_start, 1'b0);
         chk("R1 idle solver", solver_start, 1'b0);
      end
   endtask

   task automatic check_step(input int k, input int l);
      chk("R2/R3 step_tick", step_tick, exp_tick(k));
      chk("R4 comp_start", comp_start, exp_tick(k));
      chk("R5 solver_start", solver_start, exp_sstart(k));
      chk("R6/R7 overrun", overrun, exp_ovr(k, l));
   endtask

   task automatic run_trial(input int l, input int nsteps);
      do_reset();
      lat = l; model_on = 1;
      run_en = 1;
      for (int k = 0; k <= nsteps * N; k++) begin
         cyc();
         check_step(k, l);
      end
      run_en = 0;
      cyc();
   endtask

   initial begin
      int seed_v;
      seed_v = $urandom(32'h5eed_0042);

      // Directed deadline corners: last on-time latency and first late one (R6, R7).
      run_trial(1, 2);
      run_trial(N - 1, 3);
      run_trial(N, 3);
      run_trial(N + 4, 2);

      // Constrained random latencies around the deadline.
      for (int t = 0; t < 16; t++) begin
         run_trial(1 + int'($urandom % (N + 3)), 3);
      end

      // R8: done in the comp_start cycle is ignored; the solve then overruns.
      do_reset();
      run_en = 1;
      cyc();
      chk("R8 comp cycle", comp_start, 1'b1);
      solver_done = 1;
      cyc();
      solver_done = 0;
      for (int k = 2; k <= N; k++) begin
         cyc();
         if (k < N) chk("R8 overrun stays low before boundary", overrun, 1'b0);
      end
      chk("R8 stray done does not finish solve", overrun, 1'b1);
      chk("R7 new step starts despite overrun", step_tick, 1'b1);
      // R7 sticky: later on-time solves leave the flag set.
      model_on = 1; lat = 2;
      for (int k = N + 1; k <= 3 * N; k++) begin
         cyc();
         chk("R7 sticky overrun", overrun, 1'b1);
         chk("R7 tick keeps pace", step_tick, exp_tick(k));
      end

      // R9: drop run_en mid step, then re-enable.
      do_reset();
      model_on = 1; lat = 3;
      run_en = 1;
      for (int k = 0; k <= 4; k++) begin
         cyc();
         check_step(k, 3);
      end
      run_en = 0;
      repeat (4) begin
         cyc();
         chk("R9 disabled tick", step_tick, 1'b0);
         chk("R9 disabled comp", comp_start, 1'b0);
         chk("R9 disabled solver", solver_start, 1'b0);
      end
      run_en = 1;
      for (int k = 0; k <= 2 * N + 1; k++) begin
         cyc();
         chk("R9 realigned tick", step_tick, exp_tick(k));
         chk("R9 realigned solver", solver_start, exp_sstart(k));
         chk("R9 overrun", overrun, 1'b0);
      end
      run_en = 0;
      cyc();

      if (!finished) begin
         finished = 1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule